// File: doc/BRIEF.md
# Receive Byte Queue with Control and Status Register

This block buffers bytes that a serial receiver delivers until software or a downstream engine collects them. The receiver side offers one byte per cycle through a push strobe. The consumer side takes one byte per cycle through a pop strobe, and the byte appears on a registered output port. A single 16-bit control and status word sits on a simple register bus with an address, a write strobe, write data and combinational read data. Through this word, software can hold the queue in reset, watch how full it is, choose a fill threshold, and control an interrupt.

The interrupt path has three parts. A sticky flag rises whenever the queue is running and its fill reaches the threshold. A self-clearing write-one bit clears the flag. An enable bit decides whether the flag drives the interrupt pin. Writes that land on any other address leave the block untouched, and reads from any other address return zero.

Top module: `rxq_ctrl`

## Requirements
- R1: Bits 15 and 14 and the clear bit (bit 6) of the control word always read as 0.
- R2: After system reset, the control word reads 0x0000, `irq` is 0 and `pop_data` is 0.
- R3: While the run bit (bit 13) is 0, the fill field reads 0, pushes and pops have no effect, and the queue is empty once the bit is set again.
- R4: The fill field (bits 12..8) gives the number of stored bytes. An accepted push adds one, an accepted pop removes one, and bytes leave in arrival order.
- R5: The queue holds DEPTH (default 16) bytes. A push while it is full is dropped, and the fill stays at DEPTH.
- R6: A pop while the queue is empty leaves `pop_data` at its previous value and the fill at 0.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full leave the fill unchanged and keep the byte order.
- R8: The flag (bit 7) is set on the clock edge that follows a cycle in which the run bit is 1 and the fill is greater than or equal to the level field (bits 4..0). It then stays set until it is cleared.
- R9: Writing 1 to bit 6 clears the flag, and writing 0 leaves it as it is. If the set condition of R8 holds in the same cycle as the clear, the flag stays set.
- R10: `irq` is high exactly when both the flag and the enable bit (bit 5) are 1.
- R11: `pop_data` shows the oldest byte starting in the cycle after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| push | input | 1 | Producer offers a byte |
| push_data | input | DATA_W | Byte being offered |
| pop | input | 1 | Consumer takes a byte |
| pop_data | output | DATA_W | Most recently popped byte |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the register bus carries a defined address and strobe on every cycle after reset. They also assume that push and pop are plain 0/1 levels, and that the threshold test looks at the fill and level held in registers, never at a write in flight. The stimulus changes inputs only on the falling edge. It writes to the control address almost exclusively, and it keeps the run bit set most of the time so that the fill actually moves. Directed phases then drive the full, empty, held-in-reset and set-versus-clear corners at chosen points.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CSR_W    = 16;
   localparam int RUN_BIT  = 13;
   localparam int FILL_LO  = 8;
   localparam int FILL_W   = 5;
   localparam int FLAG_BIT = 7;
   localparam int CLR_BIT  = 6;
   localparam int IEN_BIT  = 5;
   localparam int LVL_W    = 5;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((1 << PTR_W) == DEPTH);

   if (DEPTH < 2 || DEPTH > (1 << CNT_W) - 1) begin : g_bad_depth
      $error("rxq_store: DEPTH must be between 2 and 2**CNT_W-1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic              full, empty, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = run && push && !full;
   assign do_pop  = run && pop && !empty;

   if (POW2) begin : g_wrap_free
      assign wr_nx = wr_ptr + 1'b1;
      assign rd_nx = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         pop_data <= '0;
      end else if (!run) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop) begin
            rd_ptr   <= rd_nx;
            pop_data <= mem[rd_ptr];
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && push && !pop && full) |=> (count == CNT_W'(DEPTH)));
   assert_held_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count == '0));
   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> $stable(pop_data));
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
   import rxq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CSR_W-1:0]  wdata,
   input  logic [FILL_W-1:0] count,
   output logic [CSR_W-1:0]  rdata,
   output logic              run,
   output logic              irq
);
   logic             run_q, ien_q, flag_q, set_c, clr_c;
   logic [LVL_W-1:0] lvl_q;

   assign set_c = run_q && (count >= FILL_W'(lvl_q));
   assign clr_c = wr_en && wdata[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ien_q  <= 1'b0;
         lvl_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_en) begin
            run_q <= wdata[RUN_BIT];
            ien_q <= wdata[IEN_BIT];
            lvl_q <= wdata[LVL_W-1:0];
         end
         if (set_c)      flag_q <= 1'b1;
         else if (clr_c) flag_q <= 1'b0;
      end
   end

   always_comb begin
      rdata                     = '0;
      rdata[RUN_BIT]            = run_q;
      rdata[FILL_LO +: FILL_W]  = run_q ? count : '0;
      rdata[FLAG_BIT]           = flag_q;
      rdata[IEN_BIT]            = ien_q;
      rdata[LVL_W-1:0]          = lvl_q;
   end

   assign run = run_q;
   assign irq = flag_q && ien_q;

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && count >= FILL_W'(lvl_q)) |=> flag_q);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_en && wdata[CLR_BIT])) |=> flag_q);
   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[CLR_BIT] && !(run_q && count >= FILL_W'(lvl_q))) |=> !flag_q);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CSR_ADDR = 0,
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              irq
);
   if (CSR_ADDR < 0 || CSR_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("rxq_ctrl: CSR_ADDR outside the address range");
   end

   logic              sel, run;
   logic [FILL_W-1:0] count;
   logic [CSR_W-1:0]  csr_rd;

   assign sel       = (reg_addr == ADDR_W'(CSR_ADDR));
   assign reg_rdata = sel ? csr_rd : '0;

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(FILL_W)) u_store (
      .clk(clk), .rst_n(rst_n), .run(run),
      .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data), .count(count)
   );

   rxq_csr u_csr (
      .clk(clk), .rst_n(rst_n), .wr_en(sel && reg_wr), .wdata(reg_wdata),
      .count(count), .rdata(csr_rd), .run(run), .irq(irq)
   );
endmodule

// File: tb/rxq_ctrl_test.sv
`timescale 1ns/1ps
module rxq_ctrl_test;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        push = 1'b0;
   logic [7:0]  push_data = '0;
   logic        pop = 1'b0;
   logic [7:0]  pop_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   string phase = "init";

   // reference state
   logic [7:0] q[$];
   bit         m_run, m_ien, m_flag;
   bit [4:0]   m_lvl;
   bit [7:0]   m_pd;

   always #2.5 clk = ~clk;

   rxq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push(push),
      .push_data(push_data), .pop(pop), .pop_data(pop_data), .irq(irq)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s): actual %h expected %h", tag, phase, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word();
      int n = m_run ? q.size() : 0;
      return {2'b00, m_run, 5'(n), m_flag, 1'b0, m_ien, m_lvl};
   endfunction

   task automatic compare();
      chk(reg_rdata[15:14], 16'h0, "R1 reserved");
      chk({15'd0, reg_rdata[6]}, 16'h0, "R1 clear bit");
      chk({11'd0, reg_rdata[12:8]}, {11'd0, exp_word()[12:8]}, "R4 fill");
      chk({15'd0, reg_rdata[7]}, {15'd0, m_flag}, "R8 flag");
      chk(reg_rdata, exp_word(), "R3 word");
      chk({15'd0, irq}, {15'd0, m_flag & m_ien}, "R10 irq");
      chk({8'd0, pop_data}, {8'd0, m_pd}, "R11 pop_data");
   endtask

   task automatic step(input bit ps, input bit [7:0] pd, input bit pp,
                       input bit wr, input bit [15:0] wd);
      bit set_c, do_push, do_pop;
      int n;
      @(negedge clk);
      push = ps; push_data = pd; pop = pp; reg_wr = wr; reg_wdata = wd;
      @(posedge clk);
      n       = q.size();
      set_c   = m_run && (n >= int'(m_lvl));
      do_push = m_run && ps && (n < DEPTH);
      do_pop  = m_run && pp && (n > 0);
      if (!m_run) q.delete();
      else begin
         if (do_pop) m_pd = q.pop_front();
         if (do_push) q.push_back(pd);
      end
      if (set_c) m_flag = 1'b1;
      else if (wr && wd[6]) m_flag = 1'b0;
      if (wr) begin
         m_run = wd[13]; m_ien = wd[5]; m_lvl = wd[4:0];
      end
      #1;
      compare();
   endtask

   task automatic idle(); step(0, 8'h0, 0, 0, 16'h0); endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R2: reset state
      phase = "R2 reset";
      #12;
      chk(reg_rdata, 16'h0000, "R2 word");
      chk({15'd0, irq}, 16'h0, "R2 irq");
      chk({8'd0, pop_data}, 16'h0, "R2 pop_data");
      @(negedge clk); rst_n = 1'b1;
      idle();

      // R3: pushes while held are ignored
      phase = "R3 held";
      for (int i = 0; i < 4; i++) step(1, 8'(i + 8'h40), 0, 0, 16'h0);
      step(0, 0, 0, 1, 16'h2000 | 16'h001F); // run, level 31
      idle();

      // R5: fill past full
      phase = "R5 full";
      for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(i + 1), 0, 0, 16'h0);
      idle();

      // R7: push and pop together on a part-filled queue
      phase = "R7 simultaneous";
      step(0, 0, 1, 0, 16'h0);
      for (int i = 0; i < 5; i++) step(1, 8'(8'hA0 + i), 1, 0, 16'h0);

      // R6: drain past empty
      phase = "R6 empty";
      for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 1, 0, 16'h0);
      step(1, 8'h77, 1, 0, 16'h0);
      step(0, 0, 1, 0, 16'h0);
      step(0, 0, 1, 0, 16'h0);

      // R9: set wins over clear, then clear works, write 0 has no effect
      phase = "R9 clear";
      step(0, 0, 0, 1, 16'h2020);          // level 0, enable
      idle();
      step(0, 0, 0, 1, 16'h2060 | 16'h1F); // clear while set holds
      step(0, 0, 0, 1, 16'h2060 | 16'h1F); // clear with level 31
      step(0, 0, 0, 1, 16'h2020 | 16'h1F); // write 0 to clear bit
      step(0, 0, 0, 1, 16'h2023);          // level 3
      for (int i = 0; i < 4; i++) step(1, 8'(i), 0, 0, 16'h0);
      idle();

      // R3: dropping run empties the queue
      phase = "R3 drop";
      step(0, 0, 0, 1, 16'h0000);
      step(0, 0, 1, 0, 16'h0);
      step(0, 0, 0, 1, 16'h2000);
      idle();

      // random mix
      phase = "random";
      void'($urandom(32'd1234));
      for (int i = 0; i < 3000; i++) begin
         bit ps = ($urandom % 100) < 50;
         bit pp = ($urandom % 100) < 40;
         bit wr = ($urandom % 100) < 5;
         bit [15:0] wd = 16'($urandom);
         if (($urandom % 10) != 0) wd[13] = 1'b1;
         step(ps, 8'($urandom), pp, wr, wd);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule